// File: doc/BRIEF.md
# Indexed Clock-Synthesizer Parameter Bank

This block holds a small set of 16-bit parameter words for a programmable clock synthesizer. A host reaches them through an 8-bit port made of a 3-bit register-select bus, a write strobe and a read strobe. Writes and reads use separate index registers to pick a word. Each word is carried as two byte accesses, low byte first. One shared lane flip-flop decides which byte an access carries. An index moves to the next word only after its high byte has been transferred.

On the synthesizer side, a 3-bit clock select picks one parameter word. An enable bit in a dedicated override word can replace that select. The chosen word is split into a feedback multiplier, a reference divider and a post-divide shift. Selects 0 and 1 are fixed reference frequencies (25.175 MHz and 28.322 MHz). For those two selects the block raises a bypass flag so the programmable path is not used. For every other select the synthesizer output frequency is 14.318 MHz × M / (N1 × 2^shift).

Top module: `pll_param_bank`

## Requirements
- R1: A write at register-select 4 loads the write index and a write at register-select 7 loads the read index. Either write also returns the lane flip-flop to the low byte.
- R2: Each access at register-select 5 (read or write) carries bits 7:0 of the indexed word when the lane flip-flop is clear and bits 15:8 when it is set. The flip-flop toggles after every such access.
- R3: The index in use (the write index for writes, the read index for reads) increments by one after the high-byte access. It wraps from 0xFF to 0x00.
- R4: Only words 2, 3, 4, 5, 6, 7, 10 and 14 accept writes. A data write to any other index leaves the stored value unchanged, but still toggles the lane flip-flop and still advances the write index.
- R5: After synchronous reset, word 0 reads 0x6128, word 1 reads 0x623D, every other word reads 0x0000, both indices are 0 and the lane flip-flop is clear.
- R6: While bit 5 of word 14 is set, bits 2:0 of word 14 replace `clk_sel_in` as the effective select shown on `clk_sel_eff`. Otherwise `clk_sel_eff` equals `clk_sel_in`.
- R7: `syn_fixed` is 1 exactly when the effective select is 0 or 1. `syn_fixed_alt` is 1 exactly when the effective select is 1 (the 28.322 MHz reference).
- R8: For the word W picked by the effective select, `syn_m` = W[6:0]+2, `syn_n1` = W[12:8]+2 and `syn_post_shift` = W[15:13].
- R9: A read at register-select 4 returns the write index and a read at register-select 7 returns the read index. Neither read changes the indices or the lane flip-flop.
- R10: A data read of an index of 16 or above returns 0x00. Reads at register-selects 0 to 3 and 6 return 0x00, and writes there change nothing.
- R11: When the write and read strobes are both high, the cycle is treated as a write only. The read index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| host_sel | input | 3 | Register select |
| host_wr | input | 1 | Write strobe, one access per cycle high |
| host_rd | input | 1 | Read strobe, one access per cycle high |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Read data, combinational from the current state |
| clk_sel_in | input | 3 | External clock select |
| clk_sel_eff | output | 3 | Clock select after the override |
| syn_fixed | output | 1 | Effective select is a fixed reference |
| syn_fixed_alt | output | 1 | Fixed reference is the 28.322 MHz one |
| syn_m | output | 8 | Feedback multiplier M |
| syn_n1 | output | 6 | Reference divider N1 |
| syn_post_shift | output | 3 | Post-divide shift, N2 = 2^shift |

## Verification
Read data is combinational, so the byte a read returns is sampled in the same cycle the read strobe is high, before the clock edge that applies its side effects. Index loads, lane toggles and index increments show up one cycle after the strobe, and the bench sees them only through a later read. The synthesizer-side outputs depend combinationally on the stored words and on `clk_sel_in`. They are therefore sampled shortly after the clock edge that finished a word write, or shortly after `clk_sel_in` changes, with no extra delay.

// File: rtl/pll_param_pkg.sv
package pll_param_pkg;
   localparam int SEL_W = 3;
   localparam logic [SEL_W-1:0] RS_WIDX = 3'd4;
   localparam logic [SEL_W-1:0] RS_DATA = 3'd5;
   localparam logic [SEL_W-1:0] RS_RIDX = 3'd7;
endpackage

// File: rtl/pll_idx_ctrl.sv
module pll_idx_ctrl
   import pll_param_pkg::*;
#(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   input  logic             wr,
   input  logic             rd,
   input  logic [IDX_W-1:0] wdata,
   output logic [IDX_W-1:0] widx,
   output logic [IDX_W-1:0] ridx,
   output logic             hi_lane,
   output logic             data_wr
);
   logic data_rd;

   assign data_wr = wr && (sel == RS_DATA);
   // a write wins over a read in the same cycle
   assign data_rd = !wr && rd && (sel == RS_DATA);

   always_ff @(posedge clk) begin
      if (rst) begin
         widx    <= '0;
         ridx    <= '0;
         hi_lane <= 1'b0;
      end else if (wr && sel == RS_WIDX) begin
         widx    <= wdata;
         hi_lane <= 1'b0;
      end else if (wr && sel == RS_RIDX) begin
         ridx    <= wdata;
         hi_lane <= 1'b0;
      end else if (data_wr) begin
         hi_lane <= ~hi_lane;
         if (hi_lane) widx <= widx + 1'b1;
      end else if (data_rd) begin
         hi_lane <= ~hi_lane;
         if (hi_lane) ridx <= ridx + 1'b1;
      end
   end
endmodule

// File: rtl/pll_reg_array.sv
module pll_reg_array #(
   parameter int                     NUM_ENTRIES = 16,
   parameter int                     IDX_W       = 8,
   parameter int                     DATA_W      = 8,
   parameter logic [NUM_ENTRIES-1:0] WR_MASK     = 16'h44FC,
   parameter logic [2*DATA_W-1:0]    ENTRY0_INIT = 16'h6128,
   parameter logic [2*DATA_W-1:0]    ENTRY1_INIT = 16'h623D
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                hi_lane,
   input  logic [DATA_W-1:0]   wdata,
   output logic [2*DATA_W-1:0] entry_q [NUM_ENTRIES]
);
   localparam int ENTRY_W = 2 * DATA_W;
   localparam int EW      = $clog2(NUM_ENTRIES);

   logic          in_range;
   logic [EW-1:0] idx_lo;

   assign in_range = (wr_idx[IDX_W-1:EW] == '0);
   assign idx_lo   = wr_idx[EW-1:0];

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
      localparam logic [ENTRY_W-1:0] INIT =
         (g == 0) ? ENTRY0_INIT : (g == 1) ? ENTRY1_INIT : '0;
      if (WR_MASK[g]) begin : g_rw
         logic [ENTRY_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) begin
               q <= INIT;
            end else if (wr_en && in_range && idx_lo == EW'(g)) begin
               if (hi_lane) q[ENTRY_W-1:DATA_W] <= wdata;
               else         q[DATA_W-1:0]       <= wdata;
            end
         end
         assign entry_q[g] = q;
      end else begin : g_ro
         assign entry_q[g] = INIT;
      end
   end
endmodule

// File: rtl/pll_field_decode.sv
module pll_field_decode #(
   parameter int NUM_ENTRIES = 16,
   parameter int ENTRY_W     = 16,
   parameter int CSEL_W      = 3,
   parameter bit OVR_EN      = 1'b1,
   parameter int OVR_IDX     = 14,
   parameter int OVR_BIT     = 5,
   parameter int FIXED_CNT   = 2,
   parameter int M_W         = 7,
   parameter int N1_LSB      = 8,
   parameter int N1_W        = 5,
   parameter int SH_LSB      = 13,
   parameter int SH_W        = 3
) (
   input  logic [ENTRY_W-1:0] entry_q [NUM_ENTRIES],
   input  logic [CSEL_W-1:0]  clk_sel_in,
   output logic [CSEL_W-1:0]  clk_sel_eff,
   output logic               fixed,
   output logic               fixed_alt,
   output logic [M_W:0]       m_eff,
   output logic [N1_W:0]      n1_eff,
   output logic [SH_W-1:0]    post_shift
);
   localparam int EW = $clog2(NUM_ENTRIES);

   logic [ENTRY_W-1:0] word;

   if (OVR_EN) begin : g_ovr
      logic [ENTRY_W-1:0] ovr_word;
      assign ovr_word    = entry_q[OVR_IDX];
      assign clk_sel_eff = ovr_word[OVR_BIT] ? ovr_word[CSEL_W-1:0] : clk_sel_in;
   end else begin : g_plain
      assign clk_sel_eff = clk_sel_in;
   end

   assign word       = entry_q[EW'(clk_sel_eff)];
   assign fixed      = (int'(clk_sel_eff) < FIXED_CNT);
   assign fixed_alt  = (clk_sel_eff == CSEL_W'(1));
   assign m_eff      = {1'b0, word[M_W-1:0]} + (M_W+1)'(2);
   assign n1_eff     = {1'b0, word[N1_LSB +: N1_W]} + (N1_W+1)'(2);
   assign post_shift = word[SH_LSB +: SH_W];
endmodule

// File: rtl/pll_param_bank.sv
module pll_param_bank
   import pll_param_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int IDX_W       = 8,
   parameter int CSEL_W      = 3,
   parameter bit OVR_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic [CSEL_W-1:0] clk_sel_in,
   output logic [CSEL_W-1:0] clk_sel_eff,
   output logic              syn_fixed,
   output logic              syn_fixed_alt,
   output logic [7:0]        syn_m,
   output logic [5:0]        syn_n1,
   output logic [2:0]        syn_post_shift
);
   localparam int DATA_W  = 8;
   localparam int ENTRY_W = 2 * DATA_W;
   localparam int EW      = $clog2(NUM_ENTRIES);

   if ((1 << EW) != NUM_ENTRIES) begin : g_chk_pow2
      $error("NUM_ENTRIES must be a power of two");
   end
   if (NUM_ENTRIES >= (1 << IDX_W)) begin : g_chk_idx
      $error("index must be wider than the entry count");
   end
   if ((1 << CSEL_W) > NUM_ENTRIES) begin : g_chk_csel
      $error("clock select reaches past the entries");
   end
   if (IDX_W != DATA_W) begin : g_chk_width
      $error("index registers are loaded from one data byte");
   end

   logic [IDX_W-1:0]   widx, ridx;
   logic               hi_lane, data_wr;
   logic [ENTRY_W-1:0] entry_q [NUM_ENTRIES];
   logic [ENTRY_W-1:0] rd_word;
   logic               rd_in_range;

   pll_idx_ctrl #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst(rst), .sel(host_sel), .wr(host_wr), .rd(host_rd),
      .wdata(host_wdata), .widx(widx), .ridx(ridx), .hi_lane(hi_lane),
      .data_wr(data_wr)
   );

   pll_reg_array #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(data_wr), .wr_idx(widx), .hi_lane(hi_lane),
      .wdata(host_wdata), .entry_q(entry_q)
   );

   pll_field_decode #(.NUM_ENTRIES(NUM_ENTRIES), .ENTRY_W(ENTRY_W),
                      .CSEL_W(CSEL_W), .OVR_EN(OVR_EN)) u_dec (
      .entry_q(entry_q), .clk_sel_in(clk_sel_in), .clk_sel_eff(clk_sel_eff),
      .fixed(syn_fixed), .fixed_alt(syn_fixed_alt), .m_eff(syn_m),
      .n1_eff(syn_n1), .post_shift(syn_post_shift)
   );

   assign rd_in_range = (ridx[IDX_W-1:EW] == '0);
   assign rd_word     = entry_q[ridx[EW-1:0]];

   always_comb begin
      case (host_sel)
         RS_WIDX: host_rdata = widx;
         RS_RIDX: host_rdata = ridx;
         RS_DATA: begin
            if (!rd_in_range)  host_rdata = '0;
            else if (hi_lane)  host_rdata = rd_word[ENTRY_W-1:DATA_W];
            else               host_rdata = rd_word[DATA_W-1:0];
         end
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pll_param_bank_chk.sv
module pll_param_bank_chk (
   input logic       clk,
   input logic       rst,
   input logic [2:0] host_sel,
   input logic       host_wr,
   input logic       host_rd,
   input logic [7:0] host_wdata,
   input logic [7:0] widx,
   input logic [7:0] ridx,
   input logic       hi_lane,
   input logic [2:0] clk_sel_eff,
   input logic       syn_fixed
);
   p_idx_load_r1: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_sel == 3'd4) |=> (widx == $past(host_wdata) && !hi_lane));

   p_lane_toggle_r2: assert property (@(posedge clk) disable iff (rst)
      ((host_wr || host_rd) && host_sel == 3'd5) |=> (hi_lane != $past(hi_lane)));

   p_idx_adv_r3: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_sel == 3'd5 && hi_lane) |=> (widx == 8'($past(widx) + 8'd1)));

   p_fixed_range_r7: assert property (@(posedge clk) disable iff (rst)
      syn_fixed |-> (clk_sel_eff < 3'd2));

   p_idx_read_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      (host_rd && !host_wr && host_sel == 3'd4)
      |=> ($stable(widx) && $stable(ridx) && $stable(hi_lane)));

   p_wr_wins_r11: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_rd && host_sel == 3'd5) |=> $stable(ridx));
endmodule

bind pll_param_bank pll_param_bank_chk u_chk (
   .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
   .host_rd(host_rd), .host_wdata(host_wdata), .widx(widx), .ridx(ridx),
   .hi_lane(hi_lane), .clk_sel_eff(clk_sel_eff), .syn_fixed(syn_fixed)
);

// File: tb/sim_pll_param_bank.sv
module sim_pll_param_bank;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] sel = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [2:0] csel = '0;
   logic [2:0] csel_eff;
   logic       fixed, fixed_alt;
   logic [7:0] m;
   logic [5:0] n1;
   logic [2:0] sh;

   int checks = 0;
   int errors = 0;
   logic [15:0] model [16];

   always #4 clk = ~clk;

   pll_param_bank u0 (
      .clk(clk), .rst(rst), .host_sel(sel), .host_wr(wr), .host_rd(rd),
      .host_wdata(wdata), .host_rdata(rdata), .clk_sel_in(csel),
      .clk_sel_eff(csel_eff), .syn_fixed(fixed), .syn_fixed_alt(fixed_alt),
      .syn_m(m), .syn_n1(n1), .syn_post_shift(sh)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic do_wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk); sel = s; wdata = d; wr = 1'b1; rd = 1'b0;
      @(posedge clk); #1 wr = 1'b0;
   endtask

   task automatic do_rd(input logic [2:0] s, output logic [7:0] q);
      @(negedge clk); sel = s; rd = 1'b1; wr = 1'b0;
      #2 q = rdata;
      @(posedge clk); #1 rd = 1'b0;
   endtask

   task automatic do_both(input logic [7:0] d);
      @(negedge clk); sel = 3'd5; wdata = d; wr = 1'b1; rd = 1'b1;
      @(posedge clk); #1 begin wr = 1'b0; rd = 1'b0; end
   endtask

   function automatic bit writable(input int i);
      return (i >= 2 && i <= 7) || i == 10 || i == 14;
   endfunction

   task automatic set_word(input int i, input logic [15:0] v);
      do_wr(3'd4, 8'(i));
      do_wr(3'd5, v[7:0]);
      do_wr(3'd5, v[15:8]);
      if (i < 16 && writable(i)) model[i] = v;
   endtask

   task automatic check_decode(input logic [2:0] s, input logic [2:0] exp_eff);
      logic [15:0] w;
      csel = s;
      #2;
      w = model[exp_eff];
      check("R6 effective select", csel_eff, exp_eff);
      check("R7 fixed flag", fixed, exp_eff < 3'd2);
      check("R7 alt flag", fixed_alt, exp_eff == 3'd1);
      check("R8 multiplier", m, int'(w[6:0]) + 2);
      check("R8 divider", n1, int'(w[12:8]) + 2);
      check("R8 post shift", sh, w[15:13]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [7:0] q, q2;
      for (int i = 0; i < 16; i++) model[i] = 16'h0000;
      model[0] = 16'h6128;
      model[1] = 16'h623D;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R5 reset state
      do_rd(3'd4, q); check("R5 write index after reset", q, 0);
      do_rd(3'd7, q); check("R5 read index after reset", q, 0);
      do_rd(3'd5, q); check("R5 word0 low", q, 8'h28);
      do_rd(3'd5, q); check("R5 word0 high", q, 8'h61);
      do_rd(3'd5, q); check("R5 word1 low", q, 8'h3D);
      do_rd(3'd5, q); check("R5 word1 high", q, 8'h62);
      do_rd(3'd5, q); check("R5 word2 low", q, 8'h00);

      // R2 R3 R4 write sweep over all 256 indices, low byte then high byte
      do_wr(3'd4, 8'h00);
      for (int i = 0; i < 256; i++) begin
         logic [7:0] lo, hi;
         lo = 8'(i * 7 + 3);
         hi = 8'(i * 13 + 8'h91);
         do_wr(3'd5, lo);
         do_wr(3'd5, hi);
         if (i < 16 && writable(i)) model[i] = {hi, lo};
      end
      do_rd(3'd4, q); check("R3 write index wrapped after 512 bytes", q, 0);

      // R2 R4 R10 read sweep over all 256 indices
      do_wr(3'd7, 8'h00);
      for (int i = 0; i < 256; i++) begin
         do_rd(3'd5, q);
         do_rd(3'd5, q2);
         check(i < 16 ? "R4 stored word" : "R10 word beyond bank",
               {q2, q}, i < 16 ? int'(model[i]) : 0);
      end
      do_rd(3'd7, q); check("R3 read index wrapped", q, 0);

      // R1 load clears lane; R9 index read has no side effect
      do_wr(3'd7, 8'h00);
      do_rd(3'd5, q);
      do_rd(3'd7, q); check("R9 read index readback", q, 0);
      do_rd(3'd5, q); check("R9 lane kept across index read", q, 8'h61);
      do_rd(3'd5, q);
      do_wr(3'd7, 8'h03);
      do_rd(3'd7, q); check("R1 read index load", q, 3);
      do_wr(3'd4, 8'h05);
      do_wr(3'd5, 8'hEE);
      do_wr(3'd4, 8'h06);
      do_rd(3'd4, q); check("R1 write index load", q, 6);
      do_wr(3'd5, 8'h11);
      do_wr(3'd5, 8'h22);
      model[6] = 16'h2211;
      model[5] = {model[5][15:8], 8'hEE};
      do_wr(3'd7, 8'h05);
      do_rd(3'd5, q); check("R1 word5 low", q, 8'hEE);
      do_wr(3'd7, 8'h06);
      do_rd(3'd5, q); check("R1 lane cleared by index load", q, 8'h11);
      do_rd(3'd5, q); check("R2 word6 high", q, 8'h22);

      // R3 wrap from 0xFF on both indices
      do_wr(3'd4, 8'hFF);
      do_wr(3'd5, 8'h12);
      do_wr(3'd5, 8'h34);
      do_rd(3'd4, q); check("R3 write index 0xFF wraps", q, 0);
      do_wr(3'd7, 8'hFF);
      do_rd(3'd5, q); check("R10 index 0xFF reads zero", q, 0);
      do_rd(3'd5, q);
      do_rd(3'd7, q); check("R3 read index 0xFF wraps", q, 0);

      // R10 other selects
      do_wr(3'd4, 8'h09);
      do_wr(3'd6, 8'h55);
      do_wr(3'd0, 8'h44);
      do_rd(3'd6, q); check("R10 select 6 reads zero", q, 0);
      do_rd(3'd2, q); check("R10 select 2 reads zero", q, 0);
      do_rd(3'd4, q); check("R10 write at other selects ignored", q, 9);

      // R11 simultaneous strobes act as a write
      do_wr(3'd4, 8'h02);
      do_wr(3'd7, 8'h03);
      do_both(8'hAA);
      do_both(8'hBB);
      model[2] = 16'hBBAA;
      do_rd(3'd7, q); check("R11 read index unmoved", q, 3);
      do_rd(3'd4, q); check("R11 write index advanced", q, 3);
      do_wr(3'd7, 8'h02);
      do_rd(3'd5, q); check("R11 written low", q, 8'hAA);
      do_rd(3'd5, q); check("R11 written high", q, 8'hBB);

      // R6 R7 R8 decode with override off
      set_word(14, 16'h0003);
      for (int s = 0; s < 8; s++) check_decode(3'(s), 3'(s));
      // override on, forcing select 6, then 1
      set_word(14, 16'h0026);
      for (int s = 0; s < 8; s++) check_decode(3'(s), 3'd6);
      set_word(14, 16'h0021);
      for (int s = 0; s < 8; s++) check_decode(3'(s), 3'd1);
      set_word(14, 16'h001F);
      check_decode(3'd4, 3'd4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule